// File: doc/BRIEF.md
# Memory Utilization Statistics Counter

This block watches a memory controller and reports how busy it is. It keeps two 32-bit counters. The total counter advances on every clock cycle while gathering runs. The busy counter advances on each of those cycles in which the controller asserts its request-accepted strobe. Software divides the busy count by the total count to get the utilization over the sampling window, and uses the result to pick a memory clock rate.

Software drives the block through a small register bus that has a write strobe, a read strobe, a two-bit word address and 32-bit data. A two-bit command field in the control register selects one of four gathering states: idle, clear, freeze or run. To take a consistent reading, software freezes the counters, reads the busy count, reads the total count, clears, and then runs again. A limit register sets the value at which the total counter stops. Once the total counter reaches that value, the busy counter stops as well, so the ratio between them stays valid.

Top module: `mem_util_stat`

## Requirements
- R1: After reset the control register reads 0, the limit register reads 0xFFFFFFFF and both counters read 0.
- R2: Word address 0 is the control register, address 1 is the limit register, address 2 is the busy count and address 3 is the total count. A read strobe at one clock edge places the value the addressed register held just before that edge on regRdData, and the value stays there until the next read.
- R3: The command field sits in control bits 9:8, where 0 is idle, 1 is clear, 2 is freeze and 3 is run. A control write stores only that field. A control read returns the field in bits 9:8 and zero in every other bit.
- R4: While the run command is held, the total counter advances by one on each clock cycle.
- R5: While the run command is held, the busy counter advances by one on each cycle in which reqAccept is high. It does not change on cycles in which reqAccept is low.
- R6: The clear command sets both counters to zero on the next clock edge. The counters then stay at zero until a run command is written.
- R7: Under the freeze command or the idle command, neither counter changes.
- R8: The total counter stops once it equals or exceeds the limit register, and the busy counter stops with it.
- R9: Writes to the counter addresses 2 and 3 change nothing.
- R10: The busy count never exceeds the total count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| reqAccept | input | 1 | High in each cycle the memory controller accepts a request |

## Verification
The hardest case to reach is the total counter hitting its limit while requests keep arriving. The default limit is far beyond any run length, so the stimulus lowers the limit to small values and checks that both counters stop together. It also lowers the limit below a count that is already running, which checks the "equals or exceeds" stop condition. Random request patterns, limited to at most one accept every other cycle, are mixed with directed clear, freeze, idle and ignored-write sequences. A cycle-accurate bench model predicts every read.

// File: rtl/mus_pkg.sv
package mus_pkg;
  localparam int ADDR_W  = 2;
  localparam int CMD_LSB = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_BUSY  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_TOTAL = 2'd3;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_FREEZE = 2'd2,
    CMD_RUN    = 2'd3
  } musCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic run;
  } musStrobe_t;
endpackage

// File: rtl/mus_ctrl.sv
module mus_ctrl
  import mus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LIMIT_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] busyCnt,
  input  logic [DATA_W-1:0] totalCnt,
  output musStrobe_t        strb,
  output logic [DATA_W-1:0] limitReg,
  output logic [DATA_W-1:0] regRdData
);
  musCmd_t cmdReg;
  logic [DATA_W-1:0] ctrlView;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= CMD_IDLE;
      limitReg <= LIMIT_RST;
    end else if (regWr) begin
      if (regAddr == ADDR_CTRL)
        cmdReg <= musCmd_t'(regWrData[CMD_LSB +: 2]);
      else if (regAddr == ADDR_LIMIT)
        limitReg <= regWrData;
    end
  end

  always_comb begin
    strb.clr = (cmdReg == CMD_CLEAR);
    strb.run = (cmdReg == CMD_RUN);
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[CMD_LSB +: 2] = cmdReg;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:  rdMux = ctrlView;
      ADDR_LIMIT: rdMux = limitReg;
      ADDR_BUSY:  rdMux = busyCnt;
      default:    rdMux = totalCnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdData <= '0;
    else if (regRd) regRdData <= rdMux;
  end
endmodule

// File: rtl/mus_datapath.sv
module mus_datapath
  import mus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  musStrobe_t        strb,
  input  logic              reqAccept,
  input  logic [DATA_W-1:0] limitReg,
  output logic [DATA_W-1:0] busyCnt,
  output logic [DATA_W-1:0] totalCnt
);
  logic atLimit;
  logic advance;

  assign atLimit = (totalCnt >= limitReg);
  assign advance = strb.run && !atLimit;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      busyCnt  <= '0;
      totalCnt <= '0;
    end else if (advance) begin
      totalCnt <= totalCnt + 1'b1;
      if (reqAccept) busyCnt <= busyCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mem_util_stat.sv
module mem_util_stat
  import mus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LIMIT_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqAccept
);
  musStrobe_t        strb;
  logic [DATA_W-1:0] limitReg;
  logic [DATA_W-1:0] busyCnt;
  logic [DATA_W-1:0] totalCnt;

  mus_ctrl #(.DATA_W(DATA_W), .LIMIT_RST(LIMIT_RST)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWrData(regWrData),
    .busyCnt(busyCnt), .totalCnt(totalCnt),
    .strb(strb), .limitReg(limitReg), .regRdData(regRdData)
  );

  mus_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAccept(reqAccept),
    .limitReg(limitReg), .busyCnt(busyCnt), .totalCnt(totalCnt)
  );
endmodule

// File: rtl/mus_checker.sv
module mus_checker
  import mus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAccept,
  input musStrobe_t        strb,
  input logic [DATA_W-1:0] busyCnt,
  input logic [DATA_W-1:0] totalCnt,
  input logic [DATA_W-1:0] limitReg
);
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(!rstN) |-> (busyCnt == '0 && totalCnt == '0));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clr) |-> (busyCnt == '0 && totalCnt == '0));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.run) && !$past(strb.clr)) |-> ($stable(busyCnt) && $stable(totalCnt)));

  a_r4_total_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.run) && !$past(strb.clr) && ($past(totalCnt) < $past(limitReg)))
      |-> (totalCnt == $past(totalCnt) + 1'b1));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.clr) && ($past(totalCnt) >= $past(limitReg)))
      |-> ($stable(totalCnt) && $stable(busyCnt)));

  a_r5_busy_cause: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != $past(busyCnt) && !$past(strb.clr))
      |-> ($past(strb.run) && $past(reqAccept) && busyCnt == $past(busyCnt) + 1'b1));

  a_r10_busy_le_total: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= totalCnt);
endmodule

bind mem_util_stat mus_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .reqAccept(reqAccept), .strb(strb),
  .busyCnt(busyCnt), .totalCnt(totalCnt), .limitReg(limitReg)
);

// File: tb/sim_mem_util_stat.sv
module sim_mem_util_stat;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqAccept = 1'b0;
  logic        reqEn = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // bench model, built from the requirements
  logic [1:0]  mCmd;
  logic [31:0] mLimit, mBusy, mTotal, mRd;

  mem_util_stat u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqAccept(reqAccept)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0:    return {22'd0, mCmd, 8'd0};
      2'd1:    return mLimit;
      2'd2:    return mBusy;
      default: return mTotal;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCmd <= 2'd0; mLimit <= 32'hFFFF_FFFF; mBusy <= '0; mTotal <= '0; mRd <= '0;
    end else begin
      if (regRd) mRd <= modelRead(regAddr);
      if (regWr && regAddr == 2'd0) mCmd <= regWrData[9:8];
      if (regWr && regAddr == 2'd1) mLimit <= regWrData;
      if (mCmd == 2'd1) begin
        mBusy <= '0; mTotal <= '0;
      end else if (mCmd == 2'd3 && mTotal < mLimit) begin
        mTotal <= mTotal + 1;
        if (reqAccept) mBusy <= mBusy + 1;
      end
    end
  end

  // at most one accept every other cycle
  always @(negedge clk) begin
    if (reqEn) reqAccept <= !reqAccept && ($urandom % 3 != 0);
    else       reqAccept <= 1'b0;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    v = regRdData;
  endtask

  task automatic rdChk(input logic [1:0] a, input string req);
    logic [31:0] v;
    rdReg(a, v);
    check(req, v, mRd);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, b1, t1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values, R2 map
    rdReg(2'd0, v); check("R1 ctrl", v, 32'h0);
    rdReg(2'd1, v); check("R1 limit", v, 32'hFFFF_FFFF);
    rdReg(2'd2, v); check("R1 busy", v, 32'h0);
    rdReg(2'd3, v); check("R1 total", v, 32'h0);

    // R3 command field only, other bits dropped
    wrReg(2'd0, 32'hFFFF_F3FF);
    rdReg(2'd0, v); check("R3 readback", v, 32'h0000_0300);

    // R4 R5 random run, then freeze snapshot
    reqEn = 1'b1;
    idle(200);
    wrReg(2'd0, 32'h200);
    reqEn = 1'b0;
    rdChk(2'd2, "R5 busy after run");
    b1 = regRdData;
    rdChk(2'd3, "R4 total after run");
    t1 = regRdData;
    tests = tests + 1;
    if (b1 > t1 || b1 == 0) begin
      fails = fails + 1;
      $display("FAIL R10: actual busy=%0d expected <= total=%0d and nonzero", b1, t1);
    end

    // R7 frozen stays put
    idle(25);
    rdReg(2'd2, v); check("R7 busy frozen", v, b1);
    rdReg(2'd3, v); check("R7 total frozen", v, t1);

    // R9 writes to counter addresses ignored
    wrReg(2'd2, 32'h1234_5678);
    wrReg(2'd3, 32'hDEAD_BEEF);
    rdReg(2'd2, v); check("R9 busy unwritten", v, b1);
    rdReg(2'd3, v); check("R9 total unwritten", v, t1);

    // R6 clear, and no counting afterwards
    wrReg(2'd0, 32'h100);
    reqEn = 1'b1;
    idle(10);
    rdReg(2'd2, v); check("R6 busy cleared", v, 0);
    rdReg(2'd3, v); check("R6 total cleared", v, 0);
    reqEn = 1'b0;

    // R5 no requests: busy stays 0, total runs
    wrReg(2'd0, 32'h300);
    idle(30);
    wrReg(2'd0, 32'h200);
    rdReg(2'd2, v); check("R5 busy idle requests", v, 0);
    rdChk(2'd3, "R4 total no requests");

    // R8 saturation at a small limit
    wrReg(2'd0, 32'h100);
    wrReg(2'd1, 32'd50);
    rdReg(2'd1, v); check("R2 limit readback", v, 32'd50);
    reqEn = 1'b1;
    wrReg(2'd0, 32'h300);
    idle(120);
    rdReg(2'd3, v); check("R8 total saturated", v, 32'd50);
    rdChk(2'd2, "R8 busy at saturation");
    b1 = regRdData;
    idle(20);
    rdReg(2'd2, v); check("R8 busy stopped", v, b1);

    // R8 lower limit below a running count
    wrReg(2'd1, 32'd20);
    idle(10);
    rdReg(2'd3, v); check("R8 above lowered limit", v, 32'd50);
    reqEn = 1'b0;

    // R7 idle command holds
    wrReg(2'd1, 32'hFFFF_FFFF);
    wrReg(2'd0, 32'h300);
    idle(15);
    wrReg(2'd0, 32'h0);
    rdChk(2'd3, "R7 total before idle");
    t1 = regRdData;
    idle(20);
    rdReg(2'd3, v); check("R7 total idle hold", v, t1);
    rdReg(2'd0, v); check("R3 idle readback", v, 32'h0);

    // random rounds against the model
    for (int i = 0; i < 12; i++) begin
      wrReg(2'd0, 32'h100);
      wrReg(2'd1, ($urandom % 2) ? 32'hFFFF_FFFF : (32'd10 + ($urandom % 80)));
      reqEn = 1'b1;
      wrReg(2'd0, 32'h300);
      idle(20 + ($urandom % 100));
      rdChk(2'd2, "R5 live busy");
      wrReg(2'd0, 32'h200);
      rdChk(2'd2, "R5 random busy");
      rdChk(2'd3, "R4 random total");
      rdChk(2'd1, "R2 random limit");
      reqEn = 1'b0;
    end

    summary();
  end
endmodule